// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out a single push or a single pop of a whole group of registers, as one instruction requests it. The caller gives it a register-select mask, a size flag that picks the byte (10-bit) set or the word (20-bit) set, a direction flag, and a 3-bit selector that names the base register to use as the stack pointer. The block walks through the selected registers one at a time. It reads or writes memory in 10-bit bytes over a request/acknowledge handshake. It reaches the registers through a read port and a write port on the register file, and it writes the final stack pointer back when the transfer ends.

Any index register, either dedicated stack pointer, the loop counter or the program counter can serve as the pointer. Among the word registers, P always comes last in pop order. A pop can therefore load a set of registers and then redirect execution in the same instruction. When the pointer is P, the pop takes its data from the bytes that follow the instruction. Memory layout is the same for both directions: a push writes the registers in the reverse of the order a pop reads them.

Top module: `pushpop_seq`

## Requirements
- R1: While `rst` is high and after it falls, `done`, `busy`, `mem_req` and `rf_wr_en` are all low until a command starts.
- R2: A word pop loads the selected registers in the order W, X, Y, Z, S, L, U, R, T, P. The word mask bits are W=0, X=1, Y=2, Z=3, S=4, P=5, L=6, U=7, R=8, T=9, and register-file index k matches mask bit k.
- R3: A word push stores the selected registers in exactly the reverse of the R2 order, so P is stored first.
- R4: A word register moves as two bytes, with the high byte at the lower address. A push decrements the pointer before each byte write. A pop increments it after each byte read.
- R5: Byte mode moves one byte per register from A, B, C, D, F, Q, I, O (mask bits and indices 0..7). Pop order is ascending and push order is descending. In byte mode, mask bits 9:8 are ignored.
- R6: Selector codes 0..7 pick W, X, Y, Z, S, U, P, L as the pointer. After a non-empty command, the block writes the pointer's final value back to that register.
- R7: In a word pop, if the pointer register is in the mask, the block does no bus cycle and no register write for it. It only advances the pointer by two.
- R8: In a word push, if the pointer register is in the mask, the block stores the pointer's value as it was when the command started.
- R9: With an empty effective mask, `done` is high in the cycle after `start` is taken. The block makes no bus request and no register write.
- R10: `done` lasts one cycle. For a non-empty command it coincides with the pointer write-back, and `busy` is low from then on.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command; taken only when idle |
| cmd_push | input | 1 | 1 = push, 0 = pop |
| cmd_word | input | 1 | 1 = 20-bit register set, 0 = 10-bit set |
| cmd_sp_sel | input | 3 | Pointer selector (R6 codes) |
| cmd_mask | input | 10 | Register-select mask |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_word | output | 1 | Read port selects the word set |
| rf_rd_idx | output | 4 | Read port register index |
| rf_rd_data | input | 20 | Read data, same cycle; byte values in bits 9:0 |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_word | output | 1 | Write targets the word set |
| rf_wr_idx | output | 4 | Write register index |
| rf_wr_data | output | 20 | Write data; byte values in bits 9:0 |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 10 | Write byte |
| mem_ack | input | 1 | Transfer accepted; read data valid |
| mem_rdata | input | 10 | Read byte |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high, and that the register file returns the addressed value combinationally in the same cycle. They also assume that `start` arrives only while `busy` is low, so one command never overlaps another. The stimulus respects these points: the memory responder derives its acknowledge from the request it sees and stalls it at pseudo-random intervals, and the driver issues each command only after the previous `done` and a short idle gap.

// File: rtl/pushpop_pkg.sv
`timescale 1ns/1ps
package pushpop_pkg;
  localparam int NUM_WREG  = 10;
  localparam int NUM_BREG  = 8;
  localparam int NUM_SLOT  = NUM_WREG;
  localparam int REG_IDX_W = 4;
  localparam logic [REG_IDX_W-1:0] REG_P = 4'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_XFER, ST_WB} pp_state_e;

  // Pointer selector to word-register index.
  function automatic logic [REG_IDX_W-1:0] sp_reg(input logic [2:0] sel);
    case (sel)
      3'd0:    return 4'd0;  // W
      3'd1:    return 4'd1;  // X
      3'd2:    return 4'd2;  // Y
      3'd3:    return 4'd3;  // Z
      3'd4:    return 4'd4;  // S
      3'd5:    return 4'd7;  // U
      3'd6:    return 4'd5;  // P
      default: return 4'd6;  // L
    endcase
  endfunction

  // Transfer slot to register index; P is moved to the end of pop order.
  function automatic logic [REG_IDX_W-1:0] slot_reg(input logic word, input logic push,
                                                    input logic [REG_IDX_W-1:0] slot);
    logic [REG_IDX_W-1:0] k;
    if (word) k = push ? 4'(NUM_WREG-1) - slot : slot;
    else      k = push ? 4'(NUM_BREG-1) - slot : slot;
    if (word) begin
      if (k == 4'(NUM_WREG-1)) return REG_P;
      if (k >= REG_P)          return k + 4'd1;
    end
    return k;
  endfunction
endpackage

// File: rtl/pushpop_order.sv
`timescale 1ns/1ps
module pushpop_order
  import pushpop_pkg::*;
#(
  parameter int NSLOT = NUM_SLOT,
  parameter int NMASK = NUM_WREG
) (
  input  logic             word,
  input  logic             push,
  input  logic [NMASK-1:0] mask,
  output logic [NSLOT-1:0] pend
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [REG_IDX_W-1:0] reg_of_slot;
    assign reg_of_slot = slot_reg(word, push, REG_IDX_W'(s));
    assign pend[s] = (word || (s < NUM_BREG)) && mask[reg_of_slot];
  end
endmodule

// File: rtl/pushpop_pick.sv
`timescale 1ns/1ps
module pushpop_pick #(
  parameter int N  = 10,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pushpop_seq.sv
`timescale 1ns/1ps
module pushpop_seq
  import pushpop_pkg::*;
#(
  parameter int BYTE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  cmd_push,
  input  logic                  cmd_word,
  input  logic [2:0]            cmd_sp_sel,
  input  logic [NUM_WREG-1:0]   cmd_mask,
  output logic                  busy,
  output logic                  done,
  output logic                  rf_rd_word,
  output logic [REG_IDX_W-1:0]  rf_rd_idx,
  input  logic [2*BYTE_W-1:0]   rf_rd_data,
  output logic                  rf_wr_en,
  output logic                  rf_wr_word,
  output logic [REG_IDX_W-1:0]  rf_wr_idx,
  output logic [2*BYTE_W-1:0]   rf_wr_data,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [2*BYTE_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]     mem_wdata,
  input  logic                  mem_ack,
  input  logic [BYTE_W-1:0]     mem_rdata
);
  localparam int AW = 2 * BYTE_W;
  localparam int SW = $clog2(NUM_SLOT);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  pp_state_e            state;
  logic                 word_q, push_q, second_q;
  logic [REG_IDX_W-1:0] spreg_q, cur_q;
  logic [AW-1:0]        sp_q, sp_orig_q, buf_q;
  logic [NUM_SLOT-1:0]  pend_q, start_pend;
  logic                 pick_found;
  logic [SW-1:0]        pick_idx;
  logic [REG_IDX_W-1:0] pick_reg;
  logic [AW-1:0]        push_val;
  logic                 pick_is_sp;

  pushpop_order #(.NSLOT(NUM_SLOT), .NMASK(NUM_WREG)) u_order (
    .word (cmd_word),
    .push (cmd_push),
    .mask (cmd_mask),
    .pend (start_pend)
  );

  pushpop_pick #(.N(NUM_SLOT), .IW(SW)) u_pick (
    .pend  (pend_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign pick_reg   = slot_reg(word_q, push_q, REG_IDX_W'(pick_idx));
  assign pick_is_sp = word_q && (pick_reg == spreg_q);
  assign busy       = (state != ST_IDLE);

  // Read port: pointer while idle, the register being pushed otherwise.
  always_comb begin
    if (state == ST_IDLE) begin
      rf_rd_word = 1'b1;
      rf_rd_idx  = sp_reg(cmd_sp_sel);
    end else begin
      rf_rd_word = word_q;
      rf_rd_idx  = pick_reg;
    end
  end

  always_comb begin
    if (pick_is_sp)  push_val = sp_orig_q;
    else if (word_q) push_val = rf_rd_data;
    else             push_val = {{BYTE_W{1'b0}}, rf_rd_data[BYTE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      word_q     <= 1'b0;
      push_q     <= 1'b0;
      second_q   <= 1'b0;
      spreg_q    <= '0;
      cur_q      <= '0;
      sp_q       <= '0;
      sp_orig_q  <= '0;
      buf_q      <= '0;
      pend_q     <= '0;
      done       <= 1'b0;
      rf_wr_en   <= 1'b0;
      rf_wr_word <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      done     <= 1'b0;
      rf_wr_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            word_q    <= cmd_word;
            push_q    <= cmd_push;
            spreg_q   <= sp_reg(cmd_sp_sel);
            sp_q      <= rf_rd_data;
            sp_orig_q <= rf_rd_data;
            pend_q    <= start_pend;
            if (start_pend == '0) done  <= 1'b1;
            else                  state <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!pick_found) begin
            state <= ST_WB;
          end else begin
            pend_q[pick_idx] <= 1'b0;
            if (!push_q && pick_is_sp) begin
              sp_q <= sp_q + TWO;
            end else begin
              cur_q    <= pick_reg;
              mem_req  <= 1'b1;
              mem_we   <= push_q;
              second_q <= word_q;
              state    <= ST_XFER;
              if (push_q) begin
                mem_addr  <= sp_q - ONE;
                sp_q      <= sp_q - ONE;
                mem_wdata <= push_val[BYTE_W-1:0];
                buf_q     <= push_val;
              end else begin
                mem_addr <= sp_q;
                sp_q     <= sp_q + ONE;
              end
            end
          end
        end
        ST_XFER: begin
          if (mem_ack) begin
            if (second_q) begin
              second_q <= 1'b0;
              if (push_q) begin
                mem_addr  <= sp_q - ONE;
                sp_q      <= sp_q - ONE;
                mem_wdata <= buf_q[AW-1:BYTE_W];
              end else begin
                buf_q[AW-1:BYTE_W] <= mem_rdata;
                mem_addr <= sp_q;
                sp_q     <= sp_q + ONE;
              end
            end else begin
              mem_req <= 1'b0;
              state   <= ST_SCAN;
              if (!push_q) begin
                rf_wr_en   <= 1'b1;
                rf_wr_word <= word_q;
                rf_wr_idx  <= cur_q;
                rf_wr_data <= word_q ? {buf_q[AW-1:BYTE_W], mem_rdata}
                                     : {{BYTE_W{1'b0}}, mem_rdata};
              end
            end
          end
        end
        default: begin
          rf_wr_en   <= 1'b1;
          rf_wr_word <= 1'b1;
          rf_wr_idx  <= spreg_q;
          rf_wr_data <= sp_q;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pushpop_seq_chk.sv
`timescale 1ns/1ps
module pushpop_seq_chk #(
  parameter int BYTE_W = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                cmd_word,
  input logic [9:0]          cmd_mask,
  input logic                busy,
  input logic                done,
  input logic                rf_wr_en,
  input logic                mem_req,
  input logic                mem_ack,
  input logic                mem_we,
  input logic [2*BYTE_W-1:0] mem_addr,
  input logic [BYTE_W-1:0]   mem_wdata
);
  localparam logic [2*BYTE_W-1:0] ONE = (2*BYTE_W)'(1);

  logic empty_cmd;
  assign empty_cmd = cmd_word ? (cmd_mask == '0) : (cmd_mask[7:0] == '0);

  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (mem_req |-> (mem_we ? (mem_addr == $past(mem_addr) - ONE)
                                                  : (mem_addr == $past(mem_addr) + ONE))));

  a_r9_empty_fast: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && empty_cmd) |=> (done && !mem_req && !rf_wr_en));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_req && !busy));
endmodule

bind pushpop_seq pushpop_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cmd_word  (cmd_word),
  .cmd_mask  (cmd_mask),
  .busy      (busy),
  .done      (done),
  .rf_wr_en  (rf_wr_en),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/pushpop_seq_tb.sv
`timescale 1ns/1ps
module pushpop_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, cmd_push = 1'b0, cmd_word = 1'b0;
  logic [2:0]  cmd_sp_sel = '0;
  logic [9:0]  cmd_mask = '0;
  logic        busy, done, rf_rd_word, rf_wr_en, rf_wr_word;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [19:0] rf_rd_data, rf_wr_data, mem_addr;
  logic        mem_req, mem_we;
  logic [9:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [9:0]  mem_rdata = '0;

  logic [19:0] wreg [0:9];
  logic [9:0]  breg [0:7];
  logic [9:0]  mem  [0:4095];

  int n_cmp = 0, n_bad = 0;
  logic [43:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  lfsr = 8'hA5;
  logic        saw_done = 1'b0;
  logic        prev_wait = 1'b0;
  logic [19:0] prev_addr = '0;

  int word_ord [10] = '{0, 1, 2, 3, 4, 6, 7, 8, 9, 5};
  int sp_map   [8]  = '{0, 1, 2, 3, 4, 7, 5, 6};

  always #4 clk = ~clk;

  assign rf_rd_data = rf_rd_word ? wreg[rf_rd_idx] : {10'd0, breg[rf_rd_idx[2:0]]};

  pushpop_seq #(.BYTE_W(10)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd_push(cmd_push), .cmd_word(cmd_word),
    .cmd_sp_sel(cmd_sp_sel), .cmd_mask(cmd_mask), .busy(busy), .done(done),
    .rf_rd_word(rf_rd_word), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_word(rf_wr_word), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [43:0] bus_ev(input logic we, input logic [19:0] a, input logic [9:0] d);
    return {2'd0, we, 1'b0, a, 10'd0, d};
  endfunction
  function automatic logic [43:0] rf_ev(input logic w, input logic [3:0] i, input logic [19:0] d,
                                        input logic dn);
    return {2'd1, w, dn, 16'd0, i, d};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [43:0] act, input logic [43:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic score(input logic [43:0] obs);
    logic [43:0] e;
    string t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2 unexpected event", obs, '0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(obs === e, t, obs, e);
    end
  endtask

  task automatic expect_ev(input logic [43:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // One cycle: negedge sampling, memory responder and scoreboard monitor.
  task automatic step();
    logic grant;
    @(negedge clk);
    if (prev_wait) check(mem_req && (mem_addr == prev_addr), "R11 request held",
                         {24'd0, mem_addr}, {24'd0, prev_addr});
    if (rf_wr_en) begin
      score({2'd1, rf_wr_word, done, 16'd0, rf_wr_idx, rf_wr_data});
      if (rf_wr_word) wreg[rf_wr_idx] = rf_wr_data;
      else            breg[rf_wr_idx[2:0]] = rf_wr_data[9:0];
    end else if (done) begin
      score({2'd2, 1'b0, 1'b1, 40'd0});
    end
    if (done) saw_done = 1'b1;
    lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    grant = (lfsr[1:0] != 2'b00);
    mem_ack = mem_req && grant;
    if (mem_req && grant) begin
      if (mem_we) begin
        mem[mem_addr[11:0]] = mem_wdata;
        score(bus_ev(1'b1, mem_addr, mem_wdata));
      end else begin
        mem_rdata = mem[mem_addr[11:0]];
        score(bus_ev(1'b0, mem_addr, mem_rdata));
      end
    end
    prev_wait = mem_req && !grant;
    prev_addr = mem_addr;
  endtask

  task automatic run_cmd(input logic push, input logic word, input logic [2:0] sel,
                         input logic [9:0] mask, input string tag);
    int spi, nreg, pos, r;
    logic [19:0] sp, orig, val;
    logic [9:0] hi, lo;
    logic any;
    spi = sp_map[sel]; sp = wreg[spi]; orig = sp; any = 1'b0;
    nreg = word ? 10 : 8;
    for (int k = 0; k < nreg; k++) begin
      pos = push ? (nreg - 1 - k) : k;
      r = word ? word_ord[pos] : pos;
      if (!mask[r]) continue;
      any = 1'b1;
      if (word) begin
        if (push) begin
          val = (r == spi) ? orig : wreg[r];
          sp = sp - 20'd1; expect_ev(bus_ev(1'b1, sp, val[9:0]), tag);
          sp = sp - 20'd1; expect_ev(bus_ev(1'b1, sp, val[19:10]), tag);
        end else if (r == spi) begin
          sp = sp + 20'd2;
        end else begin
          hi = mem[sp[11:0]]; expect_ev(bus_ev(1'b0, sp, hi), tag); sp = sp + 20'd1;
          lo = mem[sp[11:0]]; expect_ev(bus_ev(1'b0, sp, lo), tag); sp = sp + 20'd1;
          expect_ev(rf_ev(1'b1, 4'(r), {hi, lo}, 1'b0), tag);
        end
      end else begin
        if (push) begin
          sp = sp - 20'd1; expect_ev(bus_ev(1'b1, sp, breg[r]), tag);
        end else begin
          lo = mem[sp[11:0]]; expect_ev(bus_ev(1'b0, sp, lo), tag); sp = sp + 20'd1;
          expect_ev(rf_ev(1'b0, 4'(r), {10'd0, lo}, 1'b0), tag);
        end
      end
    end
    if (any) expect_ev(rf_ev(1'b1, 4'(spi), sp, 1'b1), "R6 pointer write-back");
    else     expect_ev({2'd2, 1'b0, 1'b1, 40'd0}, "R9 empty completes");

    cmd_push = push; cmd_word = word; cmd_sp_sel = sel; cmd_mask = mask;
    saw_done = 1'b0;
    start = 1'b1;
    step();
    start = 1'b0;
    if (!any) check(done === 1'b1, "R9 done one cycle after start", {43'd0, done}, 44'd1);
    for (int n = 0; n < 400 && !saw_done; n++) step();
    step();
    check(!done && !busy, "R10 done single pulse", {42'd0, done, busy}, 44'd0);
    step();
    check(exp_q.size() == 0, "R2 all expected events seen", 44'(exp_q.size()), 44'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 10'((i * 37 + 5) & 32'h3FF);
    wreg[0] = 20'h00300; wreg[1] = 20'h00500; wreg[2] = 20'h00700; wreg[3] = 20'h00A00;
    wreg[4] = 20'h00100; wreg[5] = 20'h00C00; wreg[6] = 20'h00E00; wreg[7] = 20'h00900;
    wreg[8] = 20'h12345; wreg[9] = 20'h0ABCD;
    for (int i = 0; i < 8; i++) breg[i] = 10'(17 * (i + 1) + 256);

    repeat (4) step();
    check(!done && !busy && !mem_req && !rf_wr_en, "R1 reset outputs quiet",
          {40'd0, done, busy, mem_req, rf_wr_en}, 44'd0);
    rst = 1'b0;
    step();
    check(!done && !busy && !mem_req && !rf_wr_en, "R1 idle after reset",
          {40'd0, done, busy, mem_req, rf_wr_en}, 44'd0);

    run_cmd(1'b0, 1'b1, 3'd4, 10'h3EF, "R2 word pop order, R4 layout");
    run_cmd(1'b1, 1'b1, 3'd4, 10'h3FF, "R3 word push reverse order");
    run_cmd(1'b1, 1'b1, 3'd1, 10'h012, "R8 push includes pointer");
    run_cmd(1'b0, 1'b1, 3'd6, 10'h025, "R7 pop via P skips P");
    run_cmd(1'b0, 1'b1, 3'd3, 10'h208, "R7 pop skips pointer Z");
    run_cmd(1'b0, 1'b0, 3'd0, 10'h3FF, "R5 byte pop");
    run_cmd(1'b1, 1'b0, 3'd7, 10'h0A5, "R5 byte push");
    run_cmd(1'b0, 1'b1, 3'd2, 10'h000, "R9 empty word mask");
    run_cmd(1'b1, 1'b0, 3'd1, 10'h300, "R9 R5 byte mask high bits ignored");
    run_cmd(1'b1, 1'b1, 3'd5, 10'h020, "R3 push P first");
    run_cmd(1'b0, 1'b1, 3'd5, 10'h020, "R2 pop P last");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired (R10 completion) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
    $finish;
  end
endmodule